// File: doc/BRIEF.md
# Strongest-Touch Key Arbiter

The arbiter sits after the detection integrators of a ten-channel touch sensor. Each key supplies a signed deviation (signal minus reference, where a touch drives it negative), a raw detection flag from its integrator, a participation enable and its normal integrator limit. Among the keys taking part, only the one with the most negative deviation may report a detection. All other participating keys are suppressed even if their own integrator has confirmed a touch. The block works on key indices only. Any two keys compete whether or not they are physically close.

A key takes part only when its enable bit is set and its normal integrator limit is 2 or more. The comparison needs at least two full scans of confirmation to mean anything, so a limit below 2 turns the feature off for that key. A key that does not take part passes its raw flag straight through and cannot suppress any other key. The qualified vector is registered and changes only on the clock edge where the scan-complete strobe is high.

Top module: `aksArbiter`

## Requirements
- R1: While reset is asserted, and after it, until the first scan strobe, `qualDet` is all zeros.
- R2: `qualDet` changes only on a rising clock edge at which `scanDone` is 1. Input changes with `scanDone` at 0 have no effect on it.
- R3: A key whose `keyEn` bit is 0 gets `qualDet[i] = rawDet[i]`, using the inputs sampled at the strobe.
- R4: Among participating keys, a key that is not the most negative is reported as 0, whatever its raw flag and wherever it sits in the index order.
- R5: The winning participant is reported as 1 exactly when its own `rawDet` bit is 1. Suppression never creates a detection.
- R6: When two or more participants tie for the most negative deviation, the lowest-indexed one wins.
- R7: A key whose 4-bit limit field is below 2 (for example 1) does not participate. It passes its raw flag and does not suppress others.
- R8: Deviations are 13-bit two's complement, key i at `keyDev[13*i +: 13]`, compared as signed numbers over the full range -4096 to +4095.
- R9: A non-participating key with a more negative deviation than every participant has no effect on which participant wins.
- R10: At most one participating key is reported as detected after any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scanDone | input | 1 | One-cycle strobe: a full scan of all keys has finished |
| keyDev | input | 130 | Signed 13-bit deviation per key, key i at bits [13*i +: 13] |
| keyEn | input | 10 | Per-key participation enable |
| keyLim | input | 40 | Normal integrator limit per key, key i at bits [4*i +: 4] |
| rawDet | input | 10 | Raw detection flags from the integrators |
| qualDet | output | 10 | Registered qualified detections |

## Verification
The bench targets the cases where a near-miss design still looks reasonable.

- **Tie on the most negative deviation.** A design that keeps the last minimum instead of the first would report the higher-indexed key.
- **Winner with no raw flag.** A design that granted the win without checking the raw flag would invent a touch.
- **Extreme deviations.** Values of +4095 against -1 and -4096 expose an unsigned compare, which would crown the positive key.
- **Non-participating keys with the most negative deviation.** A disabled key or a limit-1 key is given the lowest deviation. A design that let it compete would either silence every real participant or drop the key's own raw flag.
- **Input changes without a strobe.** These catch an output that is not held between scans.

// File: rtl/aksPkg.sv
package aksPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;
  } aksStrobe_t;
endpackage

// File: rtl/aksCtrl.sv
module aksCtrl
  import aksPkg::*;
#(
  parameter int N_KEYS    = 10,
  parameter int LIM_W     = 4,
  parameter int MIN_LIMIT = 2
) (
  input  logic                    scanDone,
  input  logic [N_KEYS-1:0]       keyEn,
  input  logic [N_KEYS*LIM_W-1:0] keyLim,
  output aksStrobe_t              strobe,
  output logic [N_KEYS-1:0]       partMask
);
  assign strobe.load = scanDone;

  // A key competes only when enabled and its integrator limit allows it
  for (genvar i = 0; i < N_KEYS; i++) begin : g_part
    assign partMask[i] = keyEn[i] &&
                         (int'(keyLim[i*LIM_W +: LIM_W]) >= MIN_LIMIT);
  end
endmodule

// File: rtl/aksDatapath.sv
module aksDatapath
  import aksPkg::*;
#(
  parameter int N_KEYS = 10,
  parameter int DEV_W  = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  aksStrobe_t              strobe,
  input  logic [N_KEYS-1:0]       partMask,
  input  logic [N_KEYS*DEV_W-1:0] keyDev,
  input  logic [N_KEYS-1:0]       rawDet,
  output logic [N_KEYS-1:0]       qualDet
);
  localparam int IDX_W = (N_KEYS > 1) ? $clog2(N_KEYS) : 1;

  logic signed [DEV_W-1:0] devArr [N_KEYS];
  logic signed [DEV_W-1:0] bestDev;
  logic [IDX_W-1:0]        bestIdx;
  logic                    anyPart;
  logic [N_KEYS-1:0]       nextDet;

  for (genvar i = 0; i < N_KEYS; i++) begin : g_unpack
    assign devArr[i] = keyDev[i*DEV_W +: DEV_W];
  end

  // Ascending scan with strict less-than keeps the lowest index on ties
  always_comb begin
    bestDev = '0;
    bestIdx = '0;
    anyPart = 1'b0;
    for (int k = 0; k < N_KEYS; k++) begin
      if (partMask[k] && (!anyPart || devArr[k] < bestDev)) begin
        bestDev = devArr[k];
        bestIdx = IDX_W'(k);
        anyPart = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N_KEYS; i++) begin : g_qual
    assign nextDet[i] = partMask[i] ? (rawDet[i] && (bestIdx == IDX_W'(i)))
                                    : rawDet[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           qualDet <= '0;
    else if (strobe.load) qualDet <= nextDet;
  end
endmodule

// File: rtl/aksArbiter.sv
module aksArbiter
  import aksPkg::*;
#(
  parameter int N_KEYS    = 10,
  parameter int DEV_W     = 13,
  parameter int LIM_W     = 4,
  parameter int MIN_LIMIT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scanDone,
  input  logic [N_KEYS*DEV_W-1:0] keyDev,
  input  logic [N_KEYS-1:0]       keyEn,
  input  logic [N_KEYS*LIM_W-1:0] keyLim,
  input  logic [N_KEYS-1:0]       rawDet,
  output logic [N_KEYS-1:0]       qualDet
);
  aksStrobe_t        strobe;
  logic [N_KEYS-1:0] partMask;

  aksCtrl #(.N_KEYS(N_KEYS), .LIM_W(LIM_W), .MIN_LIMIT(MIN_LIMIT)) u_ctrl (
    .scanDone(scanDone), .keyEn(keyEn), .keyLim(keyLim),
    .strobe(strobe), .partMask(partMask)
  );

  aksDatapath #(.N_KEYS(N_KEYS), .DEV_W(DEV_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .partMask(partMask),
    .keyDev(keyDev), .rawDet(rawDet), .qualDet(qualDet)
  );
endmodule

// File: rtl/aksArbiterChk.sv
module aksArbiterChk #(
  parameter int N_KEYS    = 10,
  parameter int LIM_W     = 4,
  parameter int MIN_LIMIT = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    scanDone,
  input logic [N_KEYS-1:0]       keyEn,
  input logic [N_KEYS*LIM_W-1:0] keyLim,
  input logic [N_KEYS-1:0]       rawDet,
  input logic [N_KEYS-1:0]       qualDet
);
  logic [N_KEYS-1:0] chkMask;
  always_comb begin
    for (int k = 0; k < N_KEYS; k++)
      chkMask[k] = keyEn[k] && (int'(keyLim[k*LIM_W +: LIM_W]) >= MIN_LIMIT);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> qualDet == '0);

  // R2
  hold_between_scans_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scanDone |=> $stable(qualDet));

  // R3
  bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scanDone |=> ((qualDet & ~$past(chkMask)) == ($past(rawDet) & ~$past(chkMask))));

  // R5
  no_invented_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scanDone |=> ((qualDet & ~$past(rawDet)) == '0));

  // R10
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scanDone |=> $countones(qualDet & $past(chkMask)) <= 1);
endmodule

bind aksArbiter aksArbiterChk #(.N_KEYS(N_KEYS), .LIM_W(LIM_W), .MIN_LIMIT(MIN_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scanDone(scanDone), .keyEn(keyEn),
  .keyLim(keyLim), .rawDet(rawDet), .qualDet(qualDet)
);

// File: tb/tb_aksArbiter.sv
module tb_aksArbiter;
  localparam int N = 10;
  localparam int W = 13;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scanDone = 1'b0;
  logic [N*W-1:0] keyDev = '0;
  logic [N-1:0] keyEn = '0;
  logic [N*L-1:0] keyLim = '0;
  logic [N-1:0] rawDet = '0;
  logic [N-1:0] qualDet;

  always #10 clk = ~clk;

  aksArbiter dut (
    .clk(clk), .rst_n(rst_n), .scanDone(scanDone), .keyDev(keyDev),
    .keyEn(keyEn), .keyLim(keyLim), .rawDet(rawDet), .qualDet(qualDet)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [N-1:0] exp;
    string tag;
  } item_t;
  item_t sbq[$];

  int devA [N];
  logic [N-1:0] enA, rawA;
  int limA [N];

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Model from requirements: a participant is lost if some other participant
  // is strictly lower, or equal and lower-indexed.
  function automatic logic [N-1:0] model();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      bit pi = enA[i] && limA[i] >= 2;
      bit beaten = 0;
      for (int j = 0; j < N; j++) begin
        bit pj = enA[j] && limA[j] >= 2;
        if (j != i && pi && pj && (devA[j] < devA[i] || (devA[j] == devA[i] && j < i)))
          beaten = 1;
      end
      r[i] = rawA[i] && !beaten;
    end
    return r;
  endfunction

  task automatic applyInputs();
    for (int i = 0; i < N; i++) begin
      keyDev[i*W +: W] = W'(devA[i]);
      keyLim[i*L +: L] = L'(limA[i]);
    end
    keyEn = enA;
    rawDet = rawA;
  endtask

  task automatic setDefaults();
    for (int i = 0; i < N; i++) begin
      devA[i] = 10 * i;
      limA[i] = 2;
    end
    enA = '1;
    rawA = '0;
  endtask

  // Driver: pushes expectation, strobes once, then disturbs inputs without a strobe (R2)
  task automatic applyScan(input string tag);
    item_t it;
    logic [N-1:0] held;
    it.exp = model();
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    applyInputs();
    scanDone = 1'b1;
    @(negedge clk);
    scanDone = 1'b0;
    held = it.exp;
    rawA = ~rawA;
    enA = ~enA;
    applyInputs();
    repeat (2) @(negedge clk);
    check("R2 hold without strobe", qualDet, held);
  endtask

  // Monitor: compares after the edge that sampled the strobe
  initial begin
    forever begin
      @(posedge clk);
      if (scanDone === 1'b1) begin
        @(negedge clk);
        if (sbq.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard empty actual=%b expected=none", qualDet);
        end else begin
          item_t it;
          it = sbq.pop_front();
          check(it.tag, qualDet, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", qualDet, '0);
    rst_n = 1'b1;
    setDefaults();
    rawA = '1;
    applyInputs();
    repeat (2) @(negedge clk);
    check("R1 idle after reset", qualDet, '0);

    // R4 R9 far-apart keys, winner 7
    setDefaults(); devA[7] = -900; devA[2] = -800; rawA[7] = 1; rawA[2] = 1;
    applyScan("R4 most negative wins");

    // R4 winner at index 0 suppresses key 9
    setDefaults(); devA[0] = -50; devA[9] = -49; rawA = '1;
    applyScan("R4 low index winner");

    // R5 winner has no raw flag
    setDefaults(); devA[3] = -700; devA[5] = -600; rawA[5] = 1;
    applyScan("R5 winner without raw");

    // R6 tie
    setDefaults(); devA[4] = -300; devA[8] = -300; rawA[4] = 1; rawA[8] = 1;
    applyScan("R6 tie lowest index");

    // R3 R9 disabled key with deepest deviation
    setDefaults(); enA[1] = 0; devA[1] = -4000; devA[6] = -100; rawA[1] = 1; rawA[6] = 1;
    applyScan("R3 R9 disabled key bypass");

    // R7 limit 1 key
    setDefaults(); limA[0] = 1; devA[0] = -4096; devA[9] = -50; rawA[0] = 1; rawA[9] = 1;
    applyScan("R7 limit one not participating");

    // R8 signed extremes
    setDefaults(); devA[2] = 4095; devA[5] = -1; devA[8] = 0; rawA[2] = 1; rawA[5] = 1; rawA[8] = 1;
    applyScan("R8 signed compare");

    setDefaults(); devA[3] = 4095; devA[6] = -4096; rawA[3] = 1; rawA[6] = 1;
    applyScan("R8 full range");

    // R3 none enabled
    setDefaults(); enA = '0; rawA = 10'b1011001101;
    applyScan("R3 all disabled pass through");

    // R10 all raw set, many participants
    setDefaults(); devA[5] = -2000; rawA = '1;
    applyScan("R10 single participant reported");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule